// File: doc/BRIEF.md
# Reset and Clock Start-Up Sequencer

This block holds a system in reset after power-on and lets it go only after the power-on delay and an optional power-up delay have passed. It then starts the CPU only once the chosen system clock can be trusted. All delays are counted in cycles of an always-running internal RC clock, which also clocks this block. A crystal source needs its oscillator to have run for a start-up count, and a PLL source also needs PLL lock. Both of these waits are separate from the reset delays, so the reset release can come before the clock is ready.

When fail-safe monitoring is enabled, the block checks the selected clock from the moment monitoring starts. For crystal and PLL sources, monitoring starts only after an extra settling delay that follows the reset release. If the clock is not valid at that moment, or stops being valid later, the block moves the system clock onto the internal RC oscillator and raises an oscillator-failure trap. The trap stays set until software clears it. Only a new power-on pulse moves the system clock back to the selected source.

The configuration inputs must stay stable while the power-on pulse is low.

Top module: `clkStartSeq`

## Requirements
- R1: During every cycle in which `porReq` is high, and on the clock edge that follows it, `sysRstN`, `cpuRun`, `clkSel` and `trapFlag` are all 0.
- R2: `sysRstN` rises on the PorCycles-th rising edge after the last edge that sampled `porReq` high. With `cfgTimerEn`=1 it rises on the (PorCycles+PwrtCycles)-th edge instead. It then stays high until the next power-on pulse.
- R3: With `cfgMonEn`=1 and `cfgSrc` equal to 2 or 3, monitoring starts SettleCycles edges after `sysRstN` rises. A clock that is missing at that point raises `clkSel` and `trapFlag` on the next edge, and never earlier.
- R4: `cpuRun` is 1 only when monitoring has started (or the sequence has finished, if monitoring is off) and the system clock is valid. Validity depends on `cfgSrc`: 0 means internal RC and is always valid. 1 means external clock and is valid while `oscActive`=1. 2 means crystal and is valid once `oscActive` has been sampled high on OstCycles consecutive edges; a low sample restarts that count. 3 means crystal plus PLL and needs the crystal condition and `pllLocked`=1. While `clkSel`=1, the clock counts as valid.
- R5: With `cfgMonEn`=1, any edge at or after the start of monitoring that samples an invalid clock while `clkSel`=0 sets `clkSel`=1 (system clock on internal RC) and `trapFlag`=1.
- R6: With `cfgMonEn`=0, `trapFlag` and `clkSel` stay 0, no settling delay is inserted, and `cpuRun` waits for the selected clock to become valid.
- R7: A high `trapClr` on an edge clears `trapFlag`. `clkSel` stays 1 until the next power-on pulse.
- R8: A power-on pulse arriving at any point of the sequence, including after a trap, restarts the sequence from the power-on delay and returns all outputs to the values given in R1.
- R9: With `cfgSrc`=0 and monitoring enabled, no settling delay is added, no trap is ever raised, and `cpuRun` follows `sysRstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running internal RC clock |
| porReq | input | 1 | Power-on reset pulse, active high, sampled synchronously |
| cfgSrc | input | 2 | Selected clock source: 0 RC, 1 external, 2 crystal, 3 crystal with PLL |
| cfgTimerEn | input | 1 | Enables the power-up delay |
| cfgMonEn | input | 1 | Enables fail-safe clock monitoring |
| oscActive | input | 1 | Oscillator running indication (also serves as clock valid for external source) |
| pllLocked | input | 1 | PLL lock indication |
| trapClr | input | 1 | Software clear of the trap flag |
| sysRstN | output | 1 | System reset release, active low reset |
| clkSel | output | 1 | 1 when the system clock has been moved onto the internal RC |
| cpuRun | output | 1 | CPU may execute |
| trapFlag | output | 1 | Oscillator-failure trap |

## Verification
A phase counter stuck or off by one shows at the ports as `sysRstN` rising one or more edges early or late. A settling phase entered for the wrong source shifts the trap edge by SettleCycles. Both are caught in the very cycle of the shift. A wrong start-up count or fallback register shows as `cpuRun` or `trapFlag` differing from a cycle-accurate bench model within one edge of the oscillator or PLL inputs changing. For that reason, outputs are compared on every cycle of every directed and random run.

// File: rtl/clkSeqPkg.sv
package clkSeqPkg;

  typedef enum logic [1:0] {
    SRC_RC       = 2'd0,
    SRC_EXT      = 2'd1,
    SRC_XTAL     = 2'd2,
    SRC_XTAL_PLL = 2'd3
  } clkSrc_e;

  typedef enum logic [1:0] {
    PH_POR    = 2'd0,
    PH_PWRT   = 2'd1,
    PH_SETTLE = 2'd2,
    PH_RUN    = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    LIM_POR    = 2'd0,
    LIM_PWRT   = 2'd1,
    LIM_SETTLE = 2'd2
  } limSel_e;

  typedef struct packed {
    logic    cntClr;
    limSel_e limSel;
    logic    failSet;
  } seqStrobe_t;

endpackage

// File: rtl/clkSeqDatapath.sv
module clkSeqDatapath
  import clkSeqPkg::*;
#(
  parameter int PorCycles    = 16,
  parameter int PwrtCycles   = 64,
  parameter int SettleCycles = 20,
  parameter int OstCycles    = 32
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic [1:0] cfgSrc,
  input  logic       oscActive,
  input  logic       pllLocked,
  input  logic       trapClr,
  input  seqStrobe_t strobe,
  output logic       phaseDone,
  output logic       clkReady,
  output logic       clkSel,
  output logic       trapFlag
);

  localparam int MaxLim = (PorCycles > PwrtCycles)
                          ? ((PorCycles > SettleCycles) ? PorCycles : SettleCycles)
                          : ((PwrtCycles > SettleCycles) ? PwrtCycles : SettleCycles);
  localparam int CntW = $clog2(MaxLim + 1);
  localparam int OstW = $clog2(OstCycles + 1);

  logic [CntW-1:0] phaseCnt;
  logic [CntW-1:0] limit;
  logic [OstW-1:0] ostCnt;
  logic            ostDone;

  // limit of the phase in progress, minus one
  always_comb begin
    unique case (strobe.limSel)
      LIM_PWRT:   limit = CntW'(PwrtCycles - 1);
      LIM_SETTLE: limit = CntW'(SettleCycles - 1);
      default:    limit = CntW'(PorCycles - 1);
    endcase
  end

  assign phaseDone = (phaseCnt == limit);

  always_ff @(posedge clk) begin
    if (strobe.cntClr) phaseCnt <= '0;
    else               phaseCnt <= phaseCnt + CntW'(1);
  end

  // oscillator start-up count: consecutive running samples, saturating
  always_ff @(posedge clk) begin
    if (porReq || !oscActive) ostCnt <= '0;
    else if (!ostDone)        ostCnt <= ostCnt + OstW'(1);
  end

  assign ostDone = (ostCnt == OstW'(OstCycles));

  always_comb begin
    unique case (clkSrc_e'(cfgSrc))
      SRC_RC:   clkReady = 1'b1;
      SRC_EXT:  clkReady = oscActive;
      SRC_XTAL: clkReady = ostDone;
      default:  clkReady = ostDone && pllLocked;
    endcase
  end

  // fallback onto the internal RC and the failure trap
  always_ff @(posedge clk) begin
    if (porReq) begin
      clkSel   <= 1'b0;
      trapFlag <= 1'b0;
    end else if (strobe.failSet) begin
      clkSel   <= 1'b1;
      trapFlag <= 1'b1;
    end else if (trapClr) begin
      trapFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/clkSeqControl.sv
module clkSeqControl
  import clkSeqPkg::*;
(
  input  logic       clk,
  input  logic       porReq,
  input  logic [1:0] cfgSrc,
  input  logic       cfgTimerEn,
  input  logic       cfgMonEn,
  input  logic       phaseDone,
  input  logic       clkReady,
  input  logic       clkSel,
  output seqStrobe_t strobe,
  output logic       sysRstN,
  output logic       cpuRun
);

  phase_e phase, phaseNext;
  logic   needSettle;

  // the settling wait applies only to monitored crystal or PLL sources
  assign needSettle = cfgMonEn &&
                      ((clkSrc_e'(cfgSrc) == SRC_XTAL) || (clkSrc_e'(cfgSrc) == SRC_XTAL_PLL));

  always_comb begin
    phaseNext      = phase;
    strobe.cntClr  = 1'b0;
    strobe.limSel  = LIM_POR;
    strobe.failSet = 1'b0;
    unique case (phase)
      PH_POR: begin
        strobe.limSel = LIM_POR;
        if (phaseDone) begin
          strobe.cntClr = 1'b1;
          if (cfgTimerEn)      phaseNext = PH_PWRT;
          else if (needSettle) phaseNext = PH_SETTLE;
          else                 phaseNext = PH_RUN;
        end
      end
      PH_PWRT: begin
        strobe.limSel = LIM_PWRT;
        if (phaseDone) begin
          strobe.cntClr = 1'b1;
          phaseNext     = needSettle ? PH_SETTLE : PH_RUN;
        end
      end
      PH_SETTLE: begin
        strobe.limSel = LIM_SETTLE;
        if (phaseDone) begin
          strobe.cntClr = 1'b1;
          phaseNext     = PH_RUN;
        end
      end
      default: begin
        strobe.cntClr  = 1'b1;
        strobe.failSet = cfgMonEn && !clkReady && !clkSel;
      end
    endcase
    if (porReq) begin
      phaseNext      = PH_POR;
      strobe.cntClr  = 1'b1;
      strobe.failSet = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    phase <= phaseNext;
  end

  assign sysRstN = (phase == PH_SETTLE) || (phase == PH_RUN);
  assign cpuRun  = (phase == PH_RUN) && (clkSel || clkReady);

endmodule

// File: rtl/clkStartSeq.sv
module clkStartSeq
  import clkSeqPkg::*;
#(
  parameter int PorCycles    = 16,
  parameter int PwrtCycles   = 64,
  parameter int SettleCycles = 20,
  parameter int OstCycles    = 32
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic [1:0] cfgSrc,
  input  logic       cfgTimerEn,
  input  logic       cfgMonEn,
  input  logic       oscActive,
  input  logic       pllLocked,
  input  logic       trapClr,
  output logic       sysRstN,
  output logic       clkSel,
  output logic       cpuRun,
  output logic       trapFlag
);

  seqStrobe_t strobe;
  logic       phaseDone;
  logic       clkReady;

  clkSeqControl u_ctrl (
    .clk        (clk),
    .porReq     (porReq),
    .cfgSrc     (cfgSrc),
    .cfgTimerEn (cfgTimerEn),
    .cfgMonEn   (cfgMonEn),
    .phaseDone  (phaseDone),
    .clkReady   (clkReady),
    .clkSel     (clkSel),
    .strobe     (strobe),
    .sysRstN    (sysRstN),
    .cpuRun     (cpuRun)
  );

  clkSeqDatapath #(
    .PorCycles    (PorCycles),
    .PwrtCycles   (PwrtCycles),
    .SettleCycles (SettleCycles),
    .OstCycles    (OstCycles)
  ) u_dp (
    .clk       (clk),
    .porReq    (porReq),
    .cfgSrc    (cfgSrc),
    .oscActive (oscActive),
    .pllLocked (pllLocked),
    .trapClr   (trapClr),
    .strobe    (strobe),
    .phaseDone (phaseDone),
    .clkReady  (clkReady),
    .clkSel    (clkSel),
    .trapFlag  (trapFlag)
  );

endmodule

// File: rtl/clkStartSeq_chk.sv
module clkStartSeq_chk (
  input logic clk,
  input logic porReq,
  input logic cfgMonEn,
  input logic trapClr,
  input logic sysRstN,
  input logic cpuRun,
  input logic clkSel,
  input logic trapFlag
);

  // R1 / R8: one edge after a power-on sample, every output is back at rest
  assert_reset_state_R1: assert property (@(posedge clk)
    porReq |=> (!sysRstN && !cpuRun && !clkSel && !trapFlag));

  // R2: the reset release never drops back without a power-on pulse
  assert_release_holds_R2: assert property (@(posedge clk) disable iff (porReq)
    sysRstN |=> sysRstN);

  // R4: the CPU never runs while the system is held in reset
  assert_run_needs_release_R4: assert property (@(posedge clk) disable iff (porReq)
    cpuRun |-> sysRstN);

  // R5: a raised trap always comes with the RC fallback
  assert_trap_has_fallback_R5: assert property (@(posedge clk) disable iff (porReq)
    trapFlag |-> clkSel);

  // R6: a trap can only appear while monitoring is enabled
  assert_no_trap_unmonitored_R6: assert property (@(posedge clk) disable iff (porReq)
    $rose(trapFlag) |-> $past(cfgMonEn));

  // R7: the fallback is sticky up to the next power-on pulse
  assert_fallback_sticky_R7: assert property (@(posedge clk) disable iff (porReq)
    clkSel |=> clkSel);

  // R7: a clear request with no new failure drops the trap
  assert_trap_clears_R7: assert property (@(posedge clk) disable iff (porReq)
    (trapClr && clkSel) |=> !trapFlag);

endmodule

bind clkStartSeq clkStartSeq_chk u_chk (
  .clk      (clk),
  .porReq   (porReq),
  .cfgMonEn (cfgMonEn),
  .trapClr  (trapClr),
  .sysRstN  (sysRstN),
  .cpuRun   (cpuRun),
  .clkSel   (clkSel),
  .trapFlag (trapFlag)
);

// File: tb/sim_clkStartSeq.sv
module sim_clkStartSeq;

  localparam int P = 16;
  localparam int W = 64;
  localparam int S = 20;
  localparam int O = 32;

  logic       clk        = 1'b0;
  logic       porReq     = 1'b1;
  logic [1:0] cfgSrc     = 2'd0;
  logic       cfgTimerEn = 1'b0;
  logic       cfgMonEn   = 1'b0;
  logic       oscActive  = 1'b0;
  logic       pllLocked  = 1'b0;
  logic       trapClr    = 1'b0;
  logic       sysRstN, clkSel, cpuRun, trapFlag;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curTag  = "R5";
  string porTag  = "R1";

  // bench model state
  int mT   = 0;
  int mOst = 0;
  bit mSel = 1'b0;
  bit mTrap = 1'b0;

  always #2.5 clk = ~clk;

  clkStartSeq #(.PorCycles(P), .PwrtCycles(W), .SettleCycles(S), .OstCycles(O)) u0 (
    .clk(clk), .porReq(porReq), .cfgSrc(cfgSrc), .cfgTimerEn(cfgTimerEn),
    .cfgMonEn(cfgMonEn), .oscActive(oscActive), .pllLocked(pllLocked),
    .trapClr(trapClr), .sysRstN(sysRstN), .clkSel(clkSel), .cpuRun(cpuRun),
    .trapFlag(trapFlag)
  );

  function automatic int releaseAt();
    return P + (cfgTimerEn ? W : 0);
  endfunction

  function automatic int monitorAt();
    return releaseAt() + ((cfgMonEn && cfgSrc >= 2'd2) ? S : 0);
  endfunction

  function automatic bit srcValid(logic [1:0] src, bit osc, int ost, bit pll);
    case (src)
      2'd0:    return 1'b1;
      2'd1:    return osc;
      2'd2:    return ost >= O;
      default: return (ost >= O) && pll;
    endcase
  endfunction

  always @(posedge clk) begin
    if (porReq) begin
      mT <= 0; mOst <= 0; mSel <= 1'b0; mTrap <= 1'b0;
    end else begin
      mT   <= mT + 1;
      mOst <= oscActive ? ((mOst < O) ? mOst + 1 : mOst) : 0;
      if (mT >= monitorAt() && cfgMonEn && !srcValid(cfgSrc, oscActive, mOst, pllLocked) && !mSel) begin
        mSel <= 1'b1; mTrap <= 1'b1;
      end else if (trapClr) begin
        mTrap <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input string name, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, name, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    bit expSys, expRun, valid;
    expSys = !porReq && (mT >= releaseAt());
    valid  = mSel || srcValid(cfgSrc, oscActive, mOst, pllLocked);
    expRun = !porReq && (mT >= monitorAt()) && valid;
    chk(porReq ? porTag : "R2", "sysRstN", sysRstN, expSys);
    chk(porReq ? porTag : "R4", "cpuRun", cpuRun, expRun);
    chk(porReq ? porTag : curTag, "trapFlag", trapFlag, porReq ? 1'b0 : mTrap);
    chk(porReq ? porTag : curTag, "clkSel", clkSel, porReq ? 1'b0 : mSel);
  endtask

  task automatic cycle();
    @(negedge clk);
    compareAll();
  endtask

  task automatic runScen(input string tag, input int src, input bit tmr, input bit mon,
                         input int len, input int oscRise, input int pllRise,
                         input int clrRate, input bit dropOk);
    curTag = tag;
    @(negedge clk);
    porReq = 1'b1; cfgSrc = 2'(src); cfgTimerEn = tmr; cfgMonEn = mon;
    oscActive = 1'b0; pllLocked = 1'b0; trapClr = 1'b0;
    repeat (3) cycle();
    porReq = 1'b0;
    for (int t = 0; t < len; t++) begin
      oscActive = (t >= oscRise) && !(dropOk && ($urandom % 40 == 0));
      pllLocked = (t >= pllRise);
      trapClr   = (clrRate != 0) && ($urandom % clrRate == 0);
      cycle();
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    // R1: reset state while the power-on pulse is held
    repeat (4) cycle();
    // R2 / R9: internal RC, timer on and off
    runScen("R9", 0, 1'b0, 1'b1, 40, 0, 0, 0, 1'b0);
    runScen("R9", 0, 1'b1, 1'b1, 100, 0, 0, 0, 1'b0);
    // R3: crystal never starts, monitored: trap just after the settle delay
    runScen("R3", 2, 1'b0, 1'b1, 60, 1000, 1000, 0, 1'b0);
    runScen("R3", 2, 1'b1, 1'b1, 120, 1000, 1000, 0, 1'b0);
    // R3: crystal good in time, PLL late
    runScen("R3", 3, 1'b0, 1'b1, 80, 0, 60, 0, 1'b0);
    // R3: crystal ready just before monitoring begins
    runScen("R3", 2, 1'b0, 1'b1, 70, 3, 0, 0, 1'b0);
    // R6: unmonitored crystal starts late, CPU waits
    runScen("R6", 2, 1'b0, 1'b0, 120, 50, 0, 0, 1'b0);
    runScen("R6", 1, 1'b1, 1'b0, 120, 90, 0, 0, 1'b1);
    // R7: trap then software clears, fallback stays
    runScen("R7", 1, 1'b0, 1'b1, 100, 1000, 0, 6, 1'b0);
    // R8: restart right after a trapped run, mid-sequence
    porTag = "R8";
    runScen("R8", 2, 1'b0, 1'b1, 25, 1000, 0, 0, 1'b0);
    runScen("R8", 3, 1'b1, 1'b1, 40, 0, 0, 0, 1'b0);
    runScen("R8", 1, 1'b0, 1'b0, 30, 0, 0, 0, 1'b0);
    porTag = "R1";
    // random runs
    for (int i = 0; i < 40; i++) begin
      int  src;
      bit  mon;
      src = int'($urandom % 4);
      mon = 1'($urandom % 4 != 0);
      runScen(!mon ? "R6" : (src == 0 ? "R9" : "R5"), src, 1'($urandom % 2), mon,
              60 + int'($urandom % 150), int'($urandom % 120), int'($urandom % 150),
              ($urandom % 2) ? 16 : 0, 1'($urandom % 2));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule